// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a block of words between one I/O device and memory over a shared system bus, one word per bus grant. Software programs a transfer direction, a device address, a memory start address and a word count through a small register port, then writes a go bit and continues with other work. For each word, the engine requests the bus and waits for a grant. It performs one transaction, drops its request for at least one cycle, and then requests the bus again. Any other bus user is held off only for the cycles the engine actually owns the bus.

The engine sits as a separate agent on a single bus, so every word costs two transactions. The first reads the word from its source into an internal holding register. The second writes that register to the destination. After the second transaction of each word, the memory address steps up by one and the remaining count steps down by one. When the count reaches zero the engine goes idle and raises a level interrupt. The interrupt stays high until software clears it.

The bus transaction itself is a valid/ready exchange. The engine raises `bus_valid` only once it holds a grant. While `bus_ready` is low it holds address, write flag and write data steady. The transaction completes on the rising edge where both are high, and read data is taken from `bus_rdata` on that edge.

Top module: `dma_steal`

## Requirements
- R1: After reset, `bus_req`, `bus_valid` and `irq` are low, and all four register offsets read back as zero.
- R2: While idle, the device address written at offset 1, the memory address written at offset 2 and the count written at offset 3 read back unchanged from the same offsets.
- R3: A write to offset 0 with bit 0 (go) set and a nonzero count makes status bit 0 (busy) and `bus_req` high from the next cycle; `bus_valid` rises only in the cycle after `bus_gnt` was seen high.
- R4: With control bit 1 (direction) at 0, each word is first read (`bus_we` low) from the device address and then written (`bus_we` high) to the current memory address, carrying the word just read.
- R5: `bus_req` is low in the cycle after every completed transaction, so each transaction has its own request and grant.
- R6: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_we` and `bus_wdata` hold their values.
- R7: After each word's second transaction, the memory address (offset 2) increments by one and the remaining count (offset 3) decrements by one.
- R8: When the last word completes, `irq` and status bit 1 (done) rise in the same cycle in which busy falls.
- R9: Go with a count of zero raises `irq` in the next cycle without busy and without any bus request.
- R10: `irq` stays high until a write to offset 0 with bit 2 (clear) set; other writes leave it high.
- R11: While busy, writes to offsets 1, 2 and 3 and to the direction and go bits are ignored.
- R12: With direction 1, each word is first read from the current memory address and then written to the device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control/status, 1 device address, 2 memory address, 3 count |
| reg_wdata | input | DW (16) | Register write data |
| reg_rdata | output | DW (16) | Read data for `reg_addr`, combinational |
| irq | output | 1 | Block-complete interrupt, level |
| bus_req | output | 1 | Bus request for one transaction |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Transaction valid, only under grant |
| bus_ready | input | 1 | Transaction accepted or read data present |
| bus_addr | output | AW (16) | Transaction address |
| bus_we | output | 1 | 1 write, 0 read |
| bus_wdata | output | DW (16) | Write data (holding register) |
| bus_rdata | input | DW (16) | Read data, taken when valid and ready |

## Verification
A go write takes effect on the following rising edge, so busy and `bus_req` are due one cycle after it. `bus_valid` follows one cycle after the grant, and `bus_req` falls one cycle after each completing handshake. The interrupt and the final address and count are due one cycle after the last write handshake, and in the same cycle for a zero count. The bench drives all inputs on falling edges. It samples at the falling edge right after the edge where a result is due, and reads registers combinationally there. Bus traffic is logged by the responder on the falling edge before each completing rising edge, and the checks compare that log against sequences computed from the programmed values.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_REQ  = 2'd1,
    MV_XFER = 2'd2,
    MV_GAP  = 2'd3
  } mv_state_e;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DEV  = 2'd1;
  localparam logic [1:0] OFS_MEM  = 2'd2;
  localparam logic [1:0] OFS_CNT  = 2'd3;

  localparam int BIT_GO  = 0;
  localparam int BIT_DIR = 1;
  localparam int BIT_CLR = 2;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_DIR  = 2;

endpackage

// File: rtl/dma_steal_regs.sv
module dma_steal_regs
  import dma_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy_i,
  input  logic          done_set_i,
  input  logic [AW-1:0] cur_mem_i,
  input  logic [CW-1:0] cur_cnt_i,
  output logic          start_o,
  output logic          ld_mem_o,
  output logic          ld_cnt_o,
  output logic          dir_o,
  output logic [AW-1:0] dev_addr_o,
  output logic          irq_o
);

  logic          wr_ctrl;
  logic          clr_req;
  logic          dir_q;
  logic          done_q;
  logic [AW-1:0] dev_q;

  assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  assign clr_req  = wr_ctrl && reg_wdata[BIT_CLR];
  assign start_o  = wr_ctrl && reg_wdata[BIT_GO] && !busy_i;
  assign ld_mem_o = reg_wr && (reg_addr == OFS_MEM) && !busy_i;
  assign ld_cnt_o = reg_wr && (reg_addr == OFS_CNT) && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      dev_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_ctrl && !busy_i)
        dir_q <= reg_wdata[BIT_DIR];
      if (reg_wr && (reg_addr == OFS_DEV) && !busy_i)
        dev_q <= reg_wdata[AW-1:0];
      if (done_set_i)
        done_q <= 1'b1;
      else if (clr_req)
        done_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[ST_BUSY] = busy_i;
        reg_rdata[ST_DONE] = done_q;
        reg_rdata[ST_DIR]  = dir_q;
      end
      OFS_DEV: reg_rdata[AW-1:0] = dev_q;
      OFS_MEM: reg_rdata[AW-1:0] = cur_mem_i;
      default: reg_rdata[CW-1:0] = cur_cnt_i;
    endcase
  end

  assign dir_o      = dir_q;
  assign dev_addr_o = dev_q;
  assign irq_o      = done_q;

  // R8: the engine leaving busy is always accompanied by the interrupt
  a_r8_irq_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |-> irq_o);

  // R10: interrupt is only removed by an explicit clear write
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_req) |=> irq_o);

  // R11: configuration held steady while a block is in flight
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(dev_q) && $stable(dir_q)));

endmodule

// File: rtl/dma_steal_mover.sv
module dma_steal_mover
  import dma_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ld_mem_i,
  input  logic [AW-1:0] ld_mem_data_i,
  input  logic          ld_cnt_i,
  input  logic [CW-1:0] ld_cnt_data_i,
  input  logic          dir_i,
  input  logic [AW-1:0] dev_addr_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_valid_o,
  input  logic          bus_ready_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_we_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          busy_o,
  output logic          done_set_o,
  output logic [AW-1:0] cur_mem_o,
  output logic [CW-1:0] cur_cnt_o
);

  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  mv_state_e     state_q, state_n;
  logic          phase_q;   // 0: fetch from source, 1: store to destination
  logic [DW-1:0] hold_q;
  logic [AW-1:0] mem_q;
  logic [CW-1:0] cnt_q;
  logic          launch;
  logic          handshake;
  logic          use_mem;

  assign launch    = (state_q == MV_IDLE) && start_i && (cnt_q != '0);
  assign handshake = (state_q == MV_XFER) && bus_ready_i;

  always_comb begin
    state_n    = state_q;
    done_set_o = 1'b0;
    case (state_q)
      MV_IDLE: begin
        if (start_i) begin
          if (cnt_q == '0) done_set_o = 1'b1;
          else             state_n    = MV_REQ;
        end
      end
      MV_REQ: begin
        if (bus_gnt_i) state_n = MV_XFER;
      end
      MV_XFER: begin
        if (bus_ready_i) begin
          if (phase_q && (cnt_q == CNT_ONE)) begin
            state_n    = MV_IDLE;
            done_set_o = 1'b1;
          end else begin
            state_n = MV_GAP;
          end
        end
      end
      default: state_n = MV_REQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      phase_q <= 1'b0;
      hold_q  <= '0;
      mem_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      if (launch)
        phase_q <= 1'b0;
      if (handshake) begin
        if (!phase_q) begin
          hold_q  <= bus_rdata_i;
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          mem_q   <= mem_q + ADDR_ONE;
          cnt_q   <= cnt_q - CNT_ONE;
        end
      end
      if (ld_mem_i) mem_q <= ld_mem_data_i;
      if (ld_cnt_i) cnt_q <= ld_cnt_data_i;
    end
  end

  assign use_mem     = phase_q ^ dir_i;
  assign bus_req_o   = (state_q == MV_REQ) || (state_q == MV_XFER);
  assign bus_valid_o = (state_q == MV_XFER);
  assign bus_addr_o  = use_mem ? mem_q : dev_addr_i;
  assign bus_we_o    = phase_q;
  assign bus_wdata_o = hold_q;
  assign busy_o      = (state_q != MV_IDLE);
  assign cur_mem_o   = mem_q;
  assign cur_cnt_o   = cnt_q;

  // R3: a transaction opens only after a grant was observed
  a_r3_valid_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid_o) |-> $past(bus_gnt_i));

  // R5: request released right after every completed transaction
  a_r5_release_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && bus_ready_i) |=> !bus_req_o);

  // R6: transaction fields stay put under back-pressure
  a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

  // R7: every completed store consumes exactly one count
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && bus_ready_i && bus_we_o) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R9: a zero-length go never touches the bus
  a_r9_zero_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == MV_IDLE) && start_i && (cnt_q == '0)) |=> !bus_req_o);

endmodule

// File: rtl/dma_steal.sv
module dma_steal
  import dma_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  logic          start;
  logic          ld_mem;
  logic          ld_cnt;
  logic          dir;
  logic [AW-1:0] dev_addr;
  logic          busy;
  logic          done_set;
  logic [AW-1:0] cur_mem;
  logic [CW-1:0] cur_cnt;

  dma_steal_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy_i     (busy),
    .done_set_i (done_set),
    .cur_mem_i  (cur_mem),
    .cur_cnt_i  (cur_cnt),
    .start_o    (start),
    .ld_mem_o   (ld_mem),
    .ld_cnt_o   (ld_cnt),
    .dir_o      (dir),
    .dev_addr_o (dev_addr),
    .irq_o      (irq)
  );

  dma_steal_mover #(.AW(AW), .DW(DW), .CW(CW)) u_mover (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .ld_mem_i      (ld_mem),
    .ld_mem_data_i (reg_wdata[AW-1:0]),
    .ld_cnt_i      (ld_cnt),
    .ld_cnt_data_i (reg_wdata[CW-1:0]),
    .dir_i         (dir),
    .dev_addr_i    (dev_addr),
    .bus_req_o     (bus_req),
    .bus_gnt_i     (bus_gnt),
    .bus_valid_o   (bus_valid),
    .bus_ready_i   (bus_ready),
    .bus_addr_o    (bus_addr),
    .bus_we_o      (bus_we),
    .bus_wdata_o   (bus_wdata),
    .bus_rdata_i   (bus_rdata),
    .busy_o        (busy),
    .done_set_o    (done_set),
    .cur_mem_o     (cur_mem),
    .cur_cnt_o     (cur_cnt)
  );

endmodule

// File: tb/dma_steal_tb.sv
module dma_steal_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam logic [AW-1:0] TB_DEV = 16'hF000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic          bus_valid;
  logic          bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // responder state
  int gnt_wait = 0;
  int rdy_wait = 0;
  int gc = 0;
  int rc = 0;
  logic [DW-1:0] dev_seq = '0;
  logic [DW-1:0] dev_rx [0:63];
  int dev_rx_n = 0;
  logic [DW-1:0] mem_m [0:255];
  logic [AW-1:0] log_addr [0:127];
  logic          log_we   [0:127];
  logic [DW-1:0] log_data [0:127];
  int log_n = 0;
  int req_rises = 0;
  logic prev_req = 1'b0;

  dma_steal #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  // bus arbiter and slave model, driven on falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 1'b0; bus_ready = 1'b0; gc = 0; rc = 0; prev_req = 1'b0;
    end else begin
      if (bus_req && !prev_req) req_rises++;
      prev_req = bus_req;
      if (bus_req) begin
        if (gc >= gnt_wait) bus_gnt = 1'b1;
        else begin bus_gnt = 1'b0; gc++; end
      end else begin
        bus_gnt = 1'b0; gc = 0;
      end
      if (bus_valid) begin
        if (rc >= rdy_wait) bus_ready = 1'b1;
        else begin bus_ready = 1'b0; rc++; end
      end else begin
        bus_ready = 1'b0; rc = 0;
      end
      if (bus_valid && bus_ready) begin
        if (bus_we) begin
          if (bus_addr == TB_DEV) begin dev_rx[dev_rx_n] = bus_wdata; dev_rx_n++; end
          else mem_m[bus_addr[7:0]] = bus_wdata;
        end else begin
          if (bus_addr == TB_DEV) begin bus_rdata = dev_seq; dev_seq = dev_seq + 1'b1; end
          else bus_rdata = mem_m[bus_addr[7:0]];
        end
        if (log_n < 128) begin
          log_addr[log_n] = bus_addr;
          log_we[log_n]   = bus_we;
          log_data[log_n] = bus_we ? bus_wdata : bus_rdata;
          log_n++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int limit, output bit ok);
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  task automatic clear_log();
    log_n = 0; req_rises = 0; dev_rx_n = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check(!bus_req, "R1 bus_req", int'(bus_req), 0);
    check(!bus_valid, "R1 bus_valid", int'(bus_valid), 0);
    check(!irq, "R1 irq", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      check(d == '0, "R1 register zero", int'(d), 0);
    end
  endtask

  task automatic t_regs();
    logic [DW-1:0] d;
    wr_reg(2'd1, TB_DEV);
    wr_reg(2'd2, 16'h0010);
    wr_reg(2'd3, 16'd4);
    rd_reg(2'd1, d); check(d == TB_DEV, "R2 device addr", int'(d), int'(TB_DEV));
    rd_reg(2'd2, d); check(d == 16'h0010, "R2 memory addr", int'(d), 'h10);
    rd_reg(2'd3, d); check(d == 16'd4, "R2 count", int'(d), 4);
  endtask

  task automatic t_dev_to_mem();
    logic [DW-1:0] d;
    bit ok;
    gnt_wait = 2; rdy_wait = 0;
    dev_seq = 16'hA000;
    clear_log();
    wr_reg(2'd0, 16'h0001);
    rd_reg(2'd0, d);
    check(d[0] == 1'b1, "R3 busy after go", int'(d[0]), 1);
    check(bus_req == 1'b1, "R3 bus_req after go", int'(bus_req), 1);
    check(bus_valid == 1'b0, "R3 no valid before grant", int'(bus_valid), 0);
    wait_irq(200, ok);
    check(ok, "R8 irq raised", int'(ok), 1);
    rd_reg(2'd0, d);
    check(d[0] == 1'b0 && d[1] == 1'b1, "R8 busy low done high", int'(d[1:0]), 2);
    check(log_n == 8, "R4 transaction count", log_n, 8);
    for (int i = 0; i < 4; i++) begin
      check(log_we[2*i] == 1'b0 && log_addr[2*i] == TB_DEV, "R4 fetch from device",
            int'(log_addr[2*i]), int'(TB_DEV));
      check(log_we[2*i+1] == 1'b1 && log_addr[2*i+1] == AW'(16'h0010 + i),
            "R4 store to memory", int'(log_addr[2*i+1]), 'h10 + i);
      check(mem_m[8'h10 + 8'(i)] == DW'(16'hA000 + i), "R4 memory data",
            int'(mem_m[8'h10 + 8'(i)]), 'hA000 + i);
    end
    check(req_rises == 8, "R5 one request per transaction", req_rises, 8);
    rd_reg(2'd2, d); check(d == 16'h0014, "R7 final memory addr", int'(d), 'h14);
    rd_reg(2'd3, d); check(d == 16'd0, "R7 final count", int'(d), 0);
    wr_reg(2'd0, 16'h0004);
    check(!irq, "R10 clear", int'(irq), 0);
  endtask

  task automatic t_backpressure();
    bit ok;
    gnt_wait = 0; rdy_wait = 3;
    dev_seq = 16'h5500;
    clear_log();
    wr_reg(2'd2, 16'h0030);
    wr_reg(2'd3, 16'd2);
    wr_reg(2'd0, 16'h0001);
    wait_irq(200, ok);
    check(ok, "R6 irq under stalls", int'(ok), 1);
    check(log_n == 4, "R6 transaction count", log_n, 4);
    check(mem_m[8'h30] == 16'h5500, "R6 word 0 intact", int'(mem_m[8'h30]), 'h5500);
    check(mem_m[8'h31] == 16'h5501, "R6 word 1 intact", int'(mem_m[8'h31]), 'h5501);
    check(log_addr[1] == 16'h0030 && log_addr[3] == 16'h0031, "R6 store addresses",
          int'(log_addr[3]), 'h31);
    wr_reg(2'd0, 16'h0004);
  endtask

  task automatic t_mem_to_dev();
    bit ok;
    gnt_wait = 1; rdy_wait = 1;
    mem_m[8'h40] = 16'h1111; mem_m[8'h41] = 16'h2222; mem_m[8'h42] = 16'h3333;
    clear_log();
    wr_reg(2'd2, 16'h0040);
    wr_reg(2'd3, 16'd3);
    wr_reg(2'd0, 16'h0003);
    wait_irq(200, ok);
    check(ok, "R12 irq", int'(ok), 1);
    check(log_n == 6, "R12 transaction count", log_n, 6);
    check(log_we[0] == 1'b0 && log_addr[0] == 16'h0040, "R12 first fetch from memory",
          int'(log_addr[0]), 'h40);
    check(log_we[1] == 1'b1 && log_addr[1] == TB_DEV, "R12 store to device",
          int'(log_addr[1]), int'(TB_DEV));
    check(dev_rx_n == 3, "R12 device word count", dev_rx_n, 3);
    check(dev_rx[0] == 16'h1111 && dev_rx[1] == 16'h2222 && dev_rx[2] == 16'h3333,
          "R12 device data", int'(dev_rx[2]), 'h3333);
    wr_reg(2'd0, 16'h0004);
  endtask

  task automatic t_zero();
    logic [DW-1:0] d;
    clear_log();
    wr_reg(2'd3, 16'd0);
    wr_reg(2'd0, 16'h0001);
    check(irq == 1'b1, "R9 irq at once", int'(irq), 1);
    rd_reg(2'd0, d);
    check(d[0] == 1'b0, "R9 never busy", int'(d[0]), 0);
    repeat (5) @(negedge clk);
    check(req_rises == 0 && log_n == 0, "R9 no bus activity", req_rises, 0);
  endtask

  task automatic t_sticky();
    repeat (10) @(negedge clk);
    check(irq == 1'b1, "R10 held while idle", int'(irq), 1);
    wr_reg(2'd0, 16'h0000);
    check(irq == 1'b1, "R10 held after non-clear write", int'(irq), 1);
    wr_reg(2'd1, TB_DEV);
    check(irq == 1'b1, "R10 held after other register", int'(irq), 1);
    wr_reg(2'd0, 16'h0004);
    check(irq == 1'b0, "R10 cleared", int'(irq), 0);
  endtask

  task automatic t_busy_ignore();
    logic [DW-1:0] d;
    bit ok;
    gnt_wait = 5; rdy_wait = 0;
    dev_seq = 16'h7700;
    clear_log();
    wr_reg(2'd1, TB_DEV);
    wr_reg(2'd2, 16'h0080);
    wr_reg(2'd3, 16'd3);
    wr_reg(2'd0, 16'h0001);
    wr_reg(2'd1, 16'h1234);
    wr_reg(2'd2, 16'h0099);
    wr_reg(2'd3, 16'd77);
    wr_reg(2'd0, 16'h0003);
    wait_irq(300, ok);
    check(ok, "R11 irq", int'(ok), 1);
    rd_reg(2'd1, d); check(d == TB_DEV, "R11 device addr kept", int'(d), int'(TB_DEV));
    rd_reg(2'd2, d); check(d == 16'h0083, "R11 memory addr unaffected", int'(d), 'h83);
    rd_reg(2'd3, d); check(d == 16'd0, "R11 count unaffected", int'(d), 0);
    rd_reg(2'd0, d); check(d[2] == 1'b0, "R11 direction kept", int'(d[2]), 0);
    check(log_n == 6, "R11 no restart", log_n, 6);
    check(mem_m[8'h82] == 16'h7702, "R11 last word", int'(mem_m[8'h82]), 'h7702);
    wr_reg(2'd0, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_dev_to_mem();
    t_backpressure();
    t_mem_to_dev();
    t_zero();
    t_sticky();
    t_busy_ignore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule